// File: doc/BRIEF.md
# Microsecond Timebase and Timers

This block turns a fast system clock into a board timebase. A prescaler counts system clock cycles inside each microsecond and marks the last cycle of every microsecond with a one-cycle pulse. A second counter groups 1024 of those microseconds and marks the end of each group with its own one-cycle pulse. Slowly running logic elsewhere on the chip can use both pulses as clock enables.

A global microsecond counter advances on every microsecond pulse. A slow-control write can overwrite it with a 32-bit value, which lets boards line up their clocks from time to time. A separate cycle counter measures how long ago the last timing trigger arrived. It restarts from zero on every trigger and stops at its maximum value rather than rolling over.

The clock frequency is a parameter. The number of cycles per microsecond follows from it, and so does the width of the sub-microsecond counter. With the default of 100 MHz that counter runs from 0 to 99.

Top module: `microsecond_timebase`

## Requirements
- R1: `sub_us` counts system clock cycles from 0 to CLK_FREQ_HZ/1e6 − 1 (0..99 by default), gaining one per clock and returning to 0 after the last value.
- R2: `us_pulse` is 1 exactly in the cycle where `sub_us` holds its last value, so it is high for one clock out of every CLK_FREQ_HZ/1e6.
- R3: `kus_pulse` is high for one cycle every 1024 microsecond pulses. It coincides with the 1024th, 2048th, … `us_pulse` after reset, and `us_pulse` is also high whenever it is high.
- R4: `global_us` grows by one at each clock edge where `us_pulse` is 1, wraps from all-ones to 0, and otherwise holds its value.
- R5: When `time_load` is 1 at a clock edge, `global_us` takes `time_value` at that edge. This holds even if `us_pulse` is 1 in the same cycle, in which case the value loaded is not incremented.
- R6: When `trig_in` is 1 at a clock edge, `since_trig` becomes 0 at that edge. At every other edge it grows by one.
- R7: `since_trig` saturates at all-ones and never wraps to 0 without a trigger.
- R8: While `rst` is 1 (synchronous, active high), every counter is cleared and both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| time_load | input | 1 | Strobe that overwrites the global microsecond counter |
| time_value | input | GLOBAL_W | Value loaded into the global counter |
| trig_in | input | 1 | Timing trigger pulse |
| sub_us | output | LOCAL_W | Clock cycles elapsed within the current microsecond |
| us_pulse | output | 1 | One-cycle pulse per microsecond |
| kus_pulse | output | 1 | One-cycle pulse per 1024 microseconds |
| global_us | output | GLOBAL_W | Global time in microseconds |
| since_trig | output | TRIG_W | Clock cycles since the last trigger, saturating |

## Verification
Assertions check the following on every cycle:
- `sub_us` stays in range and steps by one between pulses.
- The millisecond pulse falls only on the last cycle of a microsecond.
- The global counter holds, increments or loads as the strobes dictate, with the load taking priority.
- The trigger counter clears on a trigger and sticks once it reaches all-ones.

Some properties can only be shown by the bench's scenarios, because they need whole periods to be counted:
- the exact period of the microsecond pulse, and that the 1024-µs pulse lands on the right microsecond;
- the wrap of the global counter from all-ones;
- actual saturation, which the bench reaches on a narrow-counter instance with a fast clock setting.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  // clock cycles in one microsecond
  function automatic int cycles_per_us(input int freq_hz);
    return freq_hz / 1000000;
  endfunction

  // bits needed to hold 0..n-1, never less than one
  function automatic int count_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int CYC     = 100,
  parameter int LOCAL_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  output logic [LOCAL_W-1:0] sub_us,
  output logic               us_pulse
);
  localparam logic [LOCAL_W-1:0] LAST = LOCAL_W'(CYC - 1);

  logic [LOCAL_W-1:0] cnt_q;
  logic               at_last;

  assign at_last  = (cnt_q == LAST);
  assign sub_us   = cnt_q;
  assign us_pulse = at_last;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R1
  sub_us_range_chk: assert property (@(posedge clk) disable iff (rst)
    sub_us <= LAST);

  // R1
  sub_us_step_chk: assert property (@(posedge clk) disable iff (rst)
    !us_pulse |=> sub_us == $past(sub_us) + 1'b1);

  // R2
  us_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    us_pulse |=> sub_us == '0);
endmodule

// File: rtl/kus_divider.sv
module kus_divider #(
  parameter int GRP_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic us_pulse,
  output logic kus_pulse
);
  logic [GRP_W-1:0] grp_q;

  assign kus_pulse = us_pulse & (&grp_q);

  always_ff @(posedge clk) begin
    if (rst)           grp_q <= '0;
    else if (us_pulse) grp_q <= grp_q + 1'b1;
  end

  // R3
  grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !us_pulse |=> $stable(grp_q));
endmodule

// File: rtl/global_us_counter.sv
module global_us_counter #(
  parameter int GLOBAL_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                us_pulse,
  input  logic                time_load,
  input  logic [GLOBAL_W-1:0] time_value,
  output logic [GLOBAL_W-1:0] global_us
);
  logic [GLOBAL_W-1:0] g_q;

  assign global_us = g_q;

  always_ff @(posedge clk) begin
    if (rst)            g_q <= '0;
    else if (time_load) g_q <= time_value;
    else if (us_pulse)  g_q <= g_q + 1'b1;
  end

  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    time_load |=> global_us == $past(time_value));

  // R4
  global_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!time_load && us_pulse) |=> global_us == $past(global_us) + 1'b1);

  // R4
  global_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!time_load && !us_pulse) |=> $stable(global_us));
endmodule

// File: rtl/trig_age_counter.sv
module trig_age_counter #(
  parameter int TRIG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_in,
  output logic [TRIG_W-1:0] since_trig
);
  logic [TRIG_W-1:0] age_q;
  logic              full;

  assign full       = &age_q;
  assign since_trig = age_q;

  always_ff @(posedge clk) begin
    if (rst)          age_q <= '0;
    else if (trig_in) age_q <= '0;
    else if (!full)   age_q <= age_q + 1'b1;
  end

  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    trig_in |=> since_trig == '0);

  // R7
  age_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig_in && (&since_trig)) |=> (&since_trig));

  // R6
  age_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig_in && !(&since_trig)) |=> since_trig == $past(since_trig) + 1'b1);
endmodule

// File: rtl/microsecond_timebase.sv
module microsecond_timebase
  import timebase_pkg::*;
#(
  parameter  int CLK_FREQ_HZ = 100000000,
  parameter  int GRP_W       = 10,
  parameter  int GLOBAL_W    = 32,
  parameter  int TRIG_W      = 32,
  localparam int CYC         = cycles_per_us(CLK_FREQ_HZ),
  localparam int LOCAL_W     = count_bits(CYC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                time_load,
  input  logic [GLOBAL_W-1:0] time_value,
  input  logic                trig_in,
  output logic [LOCAL_W-1:0]  sub_us,
  output logic                us_pulse,
  output logic                kus_pulse,
  output logic [GLOBAL_W-1:0] global_us,
  output logic [TRIG_W-1:0]   since_trig
);
  localparam logic [LOCAL_W-1:0] LAST = LOCAL_W'(CYC - 1);

  us_prescaler #(.CYC(CYC), .LOCAL_W(LOCAL_W)) u_pre (
    .clk(clk), .rst(rst), .sub_us(sub_us), .us_pulse(us_pulse));

  kus_divider #(.GRP_W(GRP_W)) u_kus (
    .clk(clk), .rst(rst), .us_pulse(us_pulse), .kus_pulse(kus_pulse));

  global_us_counter #(.GLOBAL_W(GLOBAL_W)) u_glob (
    .clk(clk), .rst(rst), .us_pulse(us_pulse), .time_load(time_load),
    .time_value(time_value), .global_us(global_us));

  trig_age_counter #(.TRIG_W(TRIG_W)) u_age (
    .clk(clk), .rst(rst), .trig_in(trig_in), .since_trig(since_trig));

  // R3
  kus_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    kus_pulse |-> (us_pulse && sub_us == LAST));

  // R3
  kus_single_chk: assert property (@(posedge clk) disable iff (rst)
    kus_pulse |=> !kus_pulse);
endmodule

// File: tb/microsecond_timebase_test.sv
module microsecond_timebase_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_f = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint n = 0;

  // main instance (default 100 MHz)
  logic        time_load = 1'b0;
  logic [31:0] time_value = '0;
  logic        trig_in = 1'b0;
  logic [6:0]  sub_us;
  logic        us_pulse, kus_pulse;
  logic [31:0] global_us, since_trig;

  microsecond_timebase uut (
    .clk(clk), .rst(rst), .time_load(time_load), .time_value(time_value),
    .trig_in(trig_in), .sub_us(sub_us), .us_pulse(us_pulse),
    .kus_pulse(kus_pulse), .global_us(global_us), .since_trig(since_trig));

  // fast instance: 4 cycles per microsecond, 8-bit trigger age
  logic        trig_f = 1'b0;
  logic [1:0]  sub_f;
  logic        us_f, kus_f;
  logic [31:0] glob_f;
  logic [7:0]  age_f;

  microsecond_timebase #(.CLK_FREQ_HZ(4000000), .TRIG_W(8)) uut_fast (
    .clk(clk), .rst(rst_f), .time_load(1'b0), .time_value(32'h0),
    .trig_in(trig_f), .sub_us(sub_f), .us_pulse(us_f),
    .kus_pulse(kus_f), .global_us(glob_f), .since_trig(age_f));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at n=%0d", req, act, exp, n);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {advance, sub_us, us_pulse, global_us}; since_trig expected = n
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{0,   0, 0, 0},
    '{5,   5, 0, 0},
    '{94, 99, 1, 0},
    '{1,   0, 0, 1},
    '{250, 50, 0, 3},
    '{49, 99, 1, 3},
    '{1,   0, 0, 4},
    '{37, 37, 0, 4}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int us_cnt, kus_cnt;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 sub_us", sub_us, 0);
    chk("R8 us_pulse", us_pulse, 0);
    chk("R8 kus_pulse", kus_pulse, 0);
    chk("R8 global_us", global_us, 0);
    chk("R8 since_trig", since_trig, 0);
    rst = 1'b0;
    n = 0;

    // vector walk: R1 R2 R4 R6
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][0]);
      chk("R1 sub_us", sub_us, VEC[v][1]);
      chk("R2 us_pulse", us_pulse, VEC[v][2]);
      chk("R4 global_us", global_us, VEC[v][3]);
      chk("R6 since_trig", since_trig, n);
    end

    // R6 trigger clears then counts again
    trig_in = 1'b1;
    step(1);
    trig_in = 1'b0;
    chk("R6 clear", since_trig, 0);
    step(3);
    chk("R6 recount", since_trig, 3);

    // R3 first 1024-us pulse at n = 102399
    step(int'(102398 - n));
    chk("R3 before", kus_pulse, 0);
    step(1);
    chk("R3 pulse", kus_pulse, 1);
    chk("R3 with us_pulse", us_pulse, 1);
    chk("R4 global at pulse", global_us, 1023);
    step(1);
    chk("R3 after", kus_pulse, 0);
    chk("R4 global after", global_us, 1024);

    // R5 plain load
    step(10);
    time_value = 32'hDEADBEEF;
    time_load = 1'b1;
    step(1);
    time_load = 1'b0;
    chk("R5 load", global_us, 32'hDEADBEEF);

    // R5 load in same cycle as us_pulse
    while (!us_pulse) step(1);
    time_value = 32'h12345678;
    time_load = 1'b1;
    step(1);
    time_load = 1'b0;
    chk("R5 priority", global_us, 32'h12345678);
    step(99);
    chk("R5 hold", global_us, 32'h12345678);
    step(1);
    chk("R4 inc after load", global_us, 32'h12345679);

    // R4 wrap from all-ones
    while (!us_pulse) step(1);
    step(1);
    time_value = 32'hFFFFFFFF;
    time_load = 1'b1;
    step(1);
    time_load = 1'b0;
    while (!us_pulse) step(1);
    chk("R4 pre-wrap", global_us, 32'hFFFFFFFF);
    step(1);
    chk("R4 wrap", global_us, 0);

    // fast instance: R2 R3 period counts, R7 saturation
    rst_f = 1'b0;
    n = 0;
    us_cnt = 0;
    kus_cnt = 0;
    for (int i = 0; i < 8192; i++) begin
      step(1);
      if (us_f) us_cnt++;
      if (kus_f) begin
        kus_cnt++;
        chk("R3 fast position", n % 4096, 4095);
      end
    end
    chk("R2 fast us count", us_cnt, 2048);
    chk("R3 fast kus count", kus_cnt, 2);
    chk("R7 saturated", age_f, 255);
    held = glob_f;
    chk("R4 fast global", held, 2048);
    step(5);
    chk("R7 stays", age_f, 255);
    trig_f = 1'b1;
    step(1);
    trig_f = 1'b0;
    chk("R6 fast clear", age_f, 0);
    step(1);
    chk("R7 restart", age_f, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule